// File: doc/BRIEF.md
# Indirect Configuration Access Port Decoder

This block sits at the front of a host bridge and turns I/O reads and writes into configuration-space transactions. Software first loads a 32-bit address register, then reads or writes a four-byte data window. When the register's enable bit is set, each data-window access becomes one request to a downstream configuration target. The request carries the bus number, the device/function number, a 10-bit dword register index and byte enables. The target's response is returned to the I/O host.

Byte, word and dword accesses are supported. Byte lanes are chosen from the low port-address bits and the access size. A byte written to the top byte of the address-register port selects between this mechanism and an alternate one. While the alternate mechanism is selected, the address register is hidden and the data window is idle. The I/O side is a simple request/acknowledge bus. The downstream side issues a one-cycle request pulse and waits for a one-cycle response.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset the address register reads 0, this mechanism is selected, and `io_ack` and `cfg_req` are low.
- R2: A dword write to the base port (default 0xCF8) loads the address register, and bits 30:28 and 1:0 always read back as 0. Writing 0xFFFFFFFF reads back 0x8FFFFFFC. Writing 0x80000000 reads back 0x80000000.
- R3: A forwarded request carries bus = address bits 23:16 and device/function = bits 15:8. Its register index is {bits 27:24, bits 7:2}.
- R4: Byte enables follow the size code on `io_size` (00 byte, 01 word, 10 or 11 dword). A byte access gives 1 << addr[1:0]. A word access gives 0011 when addr[1] is 0 and 1100 when it is 1, with addr[0] ignored. A dword access gives 1111. Write data is right-justified on `io_wdata` and is shifted up by 8 × the lane offset.
- R5: Read data comes back right-justified on `io_rdata`. It is taken from the selected lanes, and the bits above the access width are 0.
- R6: While address bit 31 is clear, data-window accesses (base+4 to base+7) issue no request. Their reads return all ones in the access width (0xFF, 0xFFFF or 0xFFFFFFFF) and their writes change nothing.
- R7: A response with `cfg_rsp_hit` low makes a read return all ones in the access width, whatever the target drives on `cfg_rsp_data`.
- R8: A byte write to base+3 selects this mechanism when data bit 0 is 1 and the alternate one when it is 0. In the alternate mode, dword reads of the base port return 0xFFFFFFFF, writes to it are ignored, and the data window issues no request. The register value survives the mode change.
- R9: Each forwarded access raises `cfg_req` for exactly one cycle. `io_ack` rises for one cycle on the edge after `cfg_rsp` is seen. An `io_req` that arrives while a request is outstanding is ignored.
- R10: Accesses that are not forwarded are acknowledged on the edge after `io_req`. This covers non-dword accesses to the address port and ports outside the eight-port range. Their reads return all ones in the access width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_req | input | 1 | One-cycle I/O access strobe |
| io_we | input | 1 | 1 = write, 0 = read |
| io_addr | input | IO_AW | I/O port address |
| io_size | input | 2 | Access size code |
| io_wdata | input | 32 | Right-justified write data |
| io_ack | output | 1 | One-cycle completion |
| io_rdata | output | 32 | Right-justified read data, valid with io_ack |
| cfg_req | output | 1 | One-cycle configuration request |
| cfg_we | output | 1 | Request is a write |
| cfg_bus | output | 8 | Bus number |
| cfg_devfn | output | 8 | Device/function number |
| cfg_reg | output | 10 | Dword register index |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_rsp | input | 1 | One-cycle response strobe |
| cfg_rsp_hit | input | 1 | Addressed function exists |
| cfg_rsp_data | input | 32 | Lane-aligned read data |

## Verification
The bench builds the block with its defaults: a 16-bit port address, a base of 0xCF8, and this mechanism selected at reset. Every port in the window, and one port well outside it, can therefore be reached with real port numbers. A small target model answers after a programmable delay. This lets a stray host strobe be injected while a request is outstanding, and lets a missing function be made to drive junk data.

// File: rtl/cfg_bridge_pkg.sv
// Shared types and helpers for the configuration access port decoder.
// Assumes a 32-bit data path with four byte lanes.
package cfg_bridge_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_WORD  = 2'b01,
        SZ_DWORD = 2'b10,
        SZ_DWALT = 2'b11
    } io_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } xact_st_e;

    // Bits of the address register that software can hold.
    localparam logic [31:0] ADDR_KEEP = 32'h8FFF_FFFC;

    // All-ones value limited to the access width.
    function automatic logic [31:0] size_ones(io_size_e s);
        case (s)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_WORD: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // Pull the addressed lanes down to bit 0 and clear the rest.
    function automatic logic [31:0] lane_extract(io_size_e s, logic [1:0] off,
                                                 logic [31:0] d);
        logic [31:0] sh;
        sh = d >> {off, 3'b000};
        return sh & size_ones(s);
    endfunction

endpackage

// File: rtl/cfg_addr_reg.sv
// Address register and mechanism-select bit.
// Assumes the strobes are already qualified by the caller's decode.
module cfg_addr_reg
    import cfg_bridge_pkg::*;
#(
    parameter logic MODE_RST = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_addr,
    input  logic        wr_mode,
    input  logic [31:0] wdata,
    output logic [31:0] addr_q,
    output logic        mode_q
);

    // Hold the masked address word and the mode bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            mode_q <= MODE_RST;
        end else begin
            if (wr_addr) addr_q <= wdata & ADDR_KEEP;
            if (wr_mode) mode_q <= wdata[0];
        end
    end

endmodule

// File: rtl/cfg_lane_map.sv
// Byte-enable and write-lane placement for one I/O access.
// Purely combinational. Word accesses ignore address bit 0 and dword
// accesses ignore both low bits.
module cfg_lane_map
    import cfg_bridge_pkg::*;
(
    input  io_size_e    size,
    input  logic [1:0]  off,
    input  logic [31:0] wdata,
    output logic [1:0]  eff_off,
    output logic [3:0]  be,
    output logic [31:0] wdata_lane
);

    // Normalise the lane offset and derive the byte enables.
    always_comb begin
        case (size)
            SZ_BYTE: begin
                eff_off = off;
                be      = 4'b0001 << off;
            end
            SZ_WORD: begin
                eff_off = {off[1], 1'b0};
                be      = off[1] ? 4'b1100 : 4'b0011;
            end
            default: begin
                eff_off = 2'b00;
                be      = 4'b1111;
            end
        endcase
    end

    // Shift right-justified data onto its lanes.
    always_comb wdata_lane = wdata << {eff_off, 3'b000};

endmodule

// File: rtl/cfg_xact_ctl.sv
// Transaction control: completes local accesses at once and forwards
// data-window accesses as a one-cycle request, then waits for the response.
// Assumes the target answers each request exactly once.
module cfg_xact_ctl
    import cfg_bridge_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int DFN_W = 8,
    parameter int REG_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_req,
    input  logic             io_we,
    input  logic             fwd,
    input  logic [31:0]      local_rdata,
    input  io_size_e         size,
    input  logic [1:0]       eff_off,
    input  logic [BUS_W-1:0] req_bus,
    input  logic [DFN_W-1:0] req_devfn,
    input  logic [REG_W-1:0] req_reg,
    input  logic [3:0]       req_be,
    input  logic [31:0]      req_wdata,
    input  logic             cfg_rsp,
    input  logic             cfg_rsp_hit,
    input  logic [31:0]      cfg_rsp_data,
    output logic             idle,
    output logic             io_ack,
    output logic [31:0]      io_rdata,
    output logic             cfg_req,
    output logic             cfg_we,
    output logic [BUS_W-1:0] cfg_bus,
    output logic [DFN_W-1:0] cfg_devfn,
    output logic [REG_W-1:0] cfg_reg,
    output logic [3:0]       cfg_be,
    output logic [31:0]      cfg_wdata
);

    xact_st_e   st;
    io_size_e   size_q;
    logic [1:0] off_q;

    always_comb idle = (st == ST_IDLE);

    // Accept, forward or complete accesses; route responses back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            io_ack    <= 1'b0;
            io_rdata  <= '0;
            cfg_req   <= 1'b0;
            cfg_we    <= 1'b0;
            cfg_bus   <= '0;
            cfg_devfn <= '0;
            cfg_reg   <= '0;
            cfg_be    <= '0;
            cfg_wdata <= '0;
            size_q    <= SZ_DWORD;
            off_q     <= '0;
        end else begin
            io_ack  <= 1'b0;
            cfg_req <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (io_req) begin
                        if (fwd) begin
                            cfg_req   <= 1'b1;
                            cfg_we    <= io_we;
                            cfg_bus   <= req_bus;
                            cfg_devfn <= req_devfn;
                            cfg_reg   <= req_reg;
                            cfg_be    <= req_be;
                            cfg_wdata <= req_wdata;
                            size_q    <= size;
                            off_q     <= eff_off;
                            st        <= ST_WAIT;
                        end else begin
                            io_ack   <= 1'b1;
                            io_rdata <= io_we ? '0 : local_rdata;
                        end
                    end
                end
                ST_WAIT: begin
                    if (cfg_rsp) begin
                        io_ack   <= 1'b1;
                        io_rdata <= cfg_we ? '0 :
                                    cfg_rsp_hit ? lane_extract(size_q, off_q, cfg_rsp_data)
                                                : size_ones(size_q);
                        st       <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cfg_port_bridge.sv
// Top: decodes the address port, mode byte and data window, and links the
// address register, lane mapping and transaction control.
// Assumes the host keeps one access outstanding and waits for io_ack.
module cfg_port_bridge
    import cfg_bridge_pkg::*;
#(
    parameter int               IO_AW    = 16,
    parameter logic [IO_AW-1:0] CFG_BASE = 16'h0CF8,
    parameter logic             MODE_RST = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_req,
    input  logic             io_we,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [1:0]       io_size,
    input  logic [31:0]      io_wdata,
    output logic             io_ack,
    output logic [31:0]      io_rdata,
    output logic             cfg_req,
    output logic             cfg_we,
    output logic [7:0]       cfg_bus,
    output logic [7:0]       cfg_devfn,
    output logic [9:0]       cfg_reg,
    output logic [3:0]       cfg_be,
    output logic [31:0]      cfg_wdata,
    input  logic             cfg_rsp,
    input  logic             cfg_rsp_hit,
    input  logic [31:0]      cfg_rsp_data
);

    localparam int               SLOT_W    = IO_AW - 2;
    localparam logic [SLOT_W-1:0] ADDR_SLOT = CFG_BASE[IO_AW-1:2];
    localparam logic [SLOT_W-1:0] DATA_SLOT = ADDR_SLOT + 1'b1;

    io_size_e    size;
    logic [1:0]  off, eff_off;
    logic        at_addr, at_data, is_dw, addr_acc, idle, fwd;
    logic        wr_addr, wr_mode, mode_q;
    logic [31:0] addr_q, local_rdata, wdata_lane;
    logic [3:0]  be;

    // Port decode for the two four-byte slots.
    always_comb begin
        size     = io_size_e'(io_size);
        off      = io_addr[1:0];
        at_addr  = (io_addr[IO_AW-1:2] == ADDR_SLOT);
        at_data  = (io_addr[IO_AW-1:2] == DATA_SLOT);
        is_dw    = io_size[1];
        addr_acc = at_addr && is_dw && mode_q;
        fwd      = at_data && mode_q && addr_q[31];
    end

    // Register write strobes, only accepted while idle.
    always_comb begin
        wr_addr = io_req && idle && io_we && addr_acc;
        wr_mode = io_req && idle && io_we && at_addr && (size == SZ_BYTE) && (off == 2'd3);
    end

    // Read data for accesses completed without the target.
    always_comb local_rdata = addr_acc ? addr_q : size_ones(size);

    cfg_addr_reg #(.MODE_RST(MODE_RST)) u_areg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_addr (wr_addr),
        .wr_mode (wr_mode),
        .wdata   (io_wdata),
        .addr_q  (addr_q),
        .mode_q  (mode_q)
    );

    cfg_lane_map u_lane (
        .size       (size),
        .off        (off),
        .wdata      (io_wdata),
        .eff_off    (eff_off),
        .be         (be),
        .wdata_lane (wdata_lane)
    );

    cfg_xact_ctl #(.BUS_W(8), .DFN_W(8), .REG_W(10)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .io_req       (io_req),
        .io_we        (io_we),
        .fwd          (fwd),
        .local_rdata  (local_rdata),
        .size         (size),
        .eff_off      (eff_off),
        .req_bus      (addr_q[23:16]),
        .req_devfn    (addr_q[15:8]),
        .req_reg      ({addr_q[27:24], addr_q[7:2]}),
        .req_be       (be),
        .req_wdata    (wdata_lane),
        .cfg_rsp      (cfg_rsp),
        .cfg_rsp_hit  (cfg_rsp_hit),
        .cfg_rsp_data (cfg_rsp_data),
        .idle         (idle),
        .io_ack       (io_ack),
        .io_rdata     (io_rdata),
        .cfg_req      (cfg_req),
        .cfg_we       (cfg_we),
        .cfg_bus      (cfg_bus),
        .cfg_devfn    (cfg_devfn),
        .cfg_reg      (cfg_reg),
        .cfg_be       (cfg_be),
        .cfg_wdata    (cfg_wdata)
    );

endmodule

// File: rtl/cfg_bridge_chk.sv
// Protocol checker for cfg_port_bridge, attached with bind.
// Assumes synchronous active-low reset held from time zero.
module cfg_bridge_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_req,
    input logic [3:0] cfg_be,
    input logic       io_ack,
    input logic       mode_q,
    input logic       addr_en
);

    // R9
    single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |=> !cfg_req);

    // R4
    be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> ($countones(cfg_be) == 1 || cfg_be == 4'b0011 ||
                     cfg_be == 4'b1100 || cfg_be == 4'b1111));

    // R6
    gated_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> (mode_q && addr_en));

    // R9
    req_ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> !io_ack);

endmodule

bind cfg_port_bridge cfg_bridge_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_req (cfg_req),
    .cfg_be  (cfg_be),
    .io_ack  (io_ack),
    .mode_q  (mode_q),
    .addr_en (addr_q[31])
);

// File: tb/cfg_port_bridge_tb.sv
`timescale 1ns/1ps
module cfg_port_bridge_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_req = 1'b0, io_we = 1'b0;
    logic [15:0] io_addr = '0;
    logic [1:0]  io_size = 2'd2;
    logic [31:0] io_wdata = '0;
    logic        io_ack;
    logic [31:0] io_rdata;
    logic        cfg_req, cfg_we;
    logic [7:0]  cfg_bus, cfg_devfn;
    logic [9:0]  cfg_reg;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic        cfg_rsp = 1'b0, cfg_rsp_hit = 1'b0;
    logic [31:0] cfg_rsp_data = '0;

    int checks = 0, fails = 0;
    int n_req = 0, lat = 1;
    logic [7:0]  cap_bus, cap_devfn;
    logic [9:0]  cap_reg;
    logic [3:0]  cap_be;
    logic [31:0] mem [16];

    always #2.5 clk = ~clk;

    cfg_port_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_we(io_we),
        .io_addr(io_addr), .io_size(io_size), .io_wdata(io_wdata),
        .io_ack(io_ack), .io_rdata(io_rdata), .cfg_req(cfg_req),
        .cfg_we(cfg_we), .cfg_bus(cfg_bus), .cfg_devfn(cfg_devfn),
        .cfg_reg(cfg_reg), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rsp(cfg_rsp), .cfg_rsp_hit(cfg_rsp_hit), .cfg_rsp_data(cfg_rsp_data)
    );

    // Target model: only bus 0 exists; missing functions drive junk data.
    always begin
        @(negedge clk);
        if (cfg_req) begin
            n_req++;
            cap_bus = cfg_bus; cap_devfn = cfg_devfn; cap_reg = cfg_reg; cap_be = cfg_be;
            if (cfg_we && cfg_bus == 8'h00)
                for (int b = 0; b < 4; b++)
                    if (cfg_be[b]) mem[cfg_reg[3:0]][b*8 +: 8] = cfg_wdata[b*8 +: 8];
            repeat (lat) @(negedge clk);
            cfg_rsp      = 1'b1;
            cfg_rsp_hit  = (cap_bus == 8'h00);
            cfg_rsp_data = cfg_rsp_hit ? mem[cap_reg[3:0]] : 32'h1234_5678;
            @(negedge clk);
            cfg_rsp = 1'b0;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_io(input logic we, input logic [15:0] a, input logic [1:0] sz,
                         input logic [31:0] wd, output logic [31:0] rd);
        int cnt;
        @(negedge clk);
        io_req = 1'b1; io_we = we; io_addr = a; io_size = sz; io_wdata = wd;
        @(negedge clk);
        io_req = 1'b0;
        cnt = 0;
        while (!io_ack && cnt < 100) begin @(negedge clk); cnt++; end
        if (!io_ack) begin
            fails++;
            $display("FAIL R9 no ack actual=0 expected=1");
        end
        rd = io_rdata;
    endtask

    // Fields: tag[91:88] we[87] addr[86:71] size[70:69] wdata[68:37] exp[36:5] req[4] be[3:0]
    localparam int NV = 28;
    localparam logic [91:0] VEC [NV] = '{
        {4'd1, 1'b0,16'hCF8,2'd2,32'h0,        32'h0000_0000,1'b0,4'h0}, // R1
        {4'd2, 1'b1,16'hCF8,2'd2,32'hFFFF_FFFF,32'h0,        1'b0,4'h0}, // R2
        {4'd2, 1'b0,16'hCF8,2'd2,32'h0,        32'h8FFF_FFFC,1'b0,4'h0}, // R2
        {4'd2, 1'b1,16'hCF8,2'd2,32'h8000_0000,32'h0,        1'b0,4'h0}, // R2
        {4'd2, 1'b0,16'hCF8,2'd2,32'h0,        32'h8000_0000,1'b0,4'h0}, // R2
        {4'd5, 1'b0,16'hCFC,2'd2,32'h0,        32'h4433_2211,1'b1,4'hF}, // R5
        {4'd4, 1'b0,16'hCFD,2'd0,32'h0,        32'h0000_0022,1'b1,4'h2}, // R4
        {4'd4, 1'b0,16'hCFF,2'd0,32'h0,        32'h0000_0044,1'b1,4'h8}, // R4
        {4'd5, 1'b0,16'hCFE,2'd1,32'h0,        32'h0000_4433,1'b1,4'hC}, // R5
        {4'd5, 1'b0,16'hCFC,2'd1,32'h0,        32'h0000_2211,1'b1,4'h3}, // R5
        {4'd4, 1'b1,16'hCFE,2'd0,32'h0000_00AB,32'h0,        1'b1,4'h4}, // R4
        {4'd4, 1'b0,16'hCFC,2'd2,32'h0,        32'h44AB_2211,1'b1,4'hF}, // R4
        {4'd4, 1'b1,16'hCFE,2'd1,32'h0000_5566,32'h0,        1'b1,4'hC}, // R4
        {4'd4, 1'b0,16'hCFC,2'd2,32'h0,        32'h5566_2211,1'b1,4'hF}, // R4
        {4'd10,1'b0,16'hCF9,2'd0,32'h0,        32'h0000_00FF,1'b0,4'h0}, // R10
        {4'd10,1'b0,16'h0080,2'd2,32'h0,       32'hFFFF_FFFF,1'b0,4'h0}, // R10
        {4'd6, 1'b1,16'hCF8,2'd2,32'h0,        32'h0,        1'b0,4'h0}, // R6
        {4'd6, 1'b0,16'hCFE,2'd1,32'h0,        32'h0000_FFFF,1'b0,4'h0}, // R6
        {4'd6, 1'b1,16'hCFC,2'd2,32'h0,        32'h0,        1'b0,4'h0}, // R6
        {4'd6, 1'b1,16'hCF8,2'd2,32'h8000_0000,32'h0,        1'b0,4'h0}, // R6
        {4'd6, 1'b0,16'hCFC,2'd2,32'h0,        32'h5566_2211,1'b1,4'hF}, // R6
        {4'd8, 1'b1,16'hCFB,2'd0,32'h0,        32'h0,        1'b0,4'h0}, // R8
        {4'd8, 1'b0,16'hCF8,2'd2,32'h0,        32'hFFFF_FFFF,1'b0,4'h0}, // R8
        {4'd8, 1'b1,16'hCF8,2'd2,32'h1234_5678,32'h0,        1'b0,4'h0}, // R8
        {4'd8, 1'b0,16'hCFC,2'd2,32'h0,        32'hFFFF_FFFF,1'b0,4'h0}, // R8
        {4'd8, 1'b1,16'hCFB,2'd0,32'h0000_0001,32'h0,        1'b0,4'h0}, // R8
        {4'd8, 1'b0,16'hCF8,2'd2,32'h0,        32'h8000_0000,1'b0,4'h0}, // R8
        {4'd4, 1'b0,16'hCFD,2'd1,32'h0,        32'h0000_2211,1'b1,4'h3}  // R4
    };

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'h0;
        mem[0] = 32'h4433_2211;
    end

    // Watchdog: counts as a failure and still prints the summary.
    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int n0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 io_ack after reset", {31'h0, io_ack}, 32'h0);
        check("R1 cfg_req after reset", {31'h0, cfg_req}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [91:0] v;
            string tg;
            v  = VEC[i];
            n0 = n_req;
            tg = $sformatf("R%0d vec%0d", v[91:88], i);
            do_io(v[87], v[86:71], v[70:69], v[68:37], rd);
            if (!v[87]) check({tg, " rdata"}, rd, v[36:5]);
            check({tg, " req count"}, n_req - n0, {31'h0, v[4]});
            if (v[4]) check({tg, " be"}, {28'h0, cap_be}, {28'h0, v[3:0]});
        end

        // R3 field packing, and R7 on a missing function (bus 0x5C)
        do_io(1'b1, 16'hCF8, 2'd2, 32'h8A5C_E3F4, rd);
        do_io(1'b0, 16'hCF8, 2'd2, 32'h0, rd);
        check("R2 readback of field word", rd, 32'h8A5C_E3F4);
        do_io(1'b0, 16'hCFC, 2'd2, 32'h0, rd);
        check("R3 bus", {24'h0, cap_bus}, 32'h5C);
        check("R3 devfn", {24'h0, cap_devfn}, 32'hE3);
        check("R3 reg index", {22'h0, cap_reg}, 32'h2BD);
        check("R7 miss dword read", rd, 32'hFFFF_FFFF);
        do_io(1'b0, 16'hCFD, 2'd0, 32'h0, rd);
        check("R7 miss byte read", rd, 32'h0000_00FF);

        // R9 single request, stray strobe while waiting, one-cycle ack
        do_io(1'b1, 16'hCF8, 2'd2, 32'h8000_0000, rd);
        lat = 4;
        n0 = n_req;
        @(negedge clk);
        io_req = 1'b1; io_we = 1'b0; io_addr = 16'hCFC; io_size = 2'd2;
        @(negedge clk);
        io_req = 1'b0;
        @(negedge clk);
        io_req = 1'b1; io_we = 1'b1; io_addr = 16'hCF8; io_wdata = 32'h0;
        @(negedge clk);
        io_req = 1'b0;
        begin
            int cnt = 0;
            while (!io_ack && cnt < 100) begin @(negedge clk); cnt++; end
        end
        check("R9 ack seen", {31'h0, io_ack}, 32'h1);
        check("R9 slow read data", io_rdata, 32'h5566_2211);
        check("R9 one request", n_req - n0, 32'd1);
        @(negedge clk);
        check("R9 ack one cycle", {31'h0, io_ack}, 32'h0);
        lat = 0;
        do_io(1'b0, 16'hCF8, 2'd2, 32'h0, rd);
        check("R9 stray write ignored", rd, 32'h8000_0000);
        do_io(1'b0, 16'hCFC, 2'd2, 32'h0, rd);
        check("R9 zero-latency target", rd, 32'h5566_2211);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule